// File: doc/BRIEF.md
# Column-Partitioned Correlator Bank

This block produces the matched-filter outputs used when estimating a sparse multipath channel. It holds one received vector `r` of `NSAMP` signed samples and a signal matrix `S` of `NSAMP` rows by `NCOL` columns. Each column of `S` is the waveform expected from one candidate path delay. On a start pulse the block computes, for every column `j`, the correlation `sum over k of r[k] * S[k][j]`. It emits one result per cycle with the column index and a valid flag, then pulses `done`.

The matrix is split by column over `LANES` independent lanes. Column `j` lives in lane `j mod LANES` at local slot `j div LANES`. Each lane keeps its own copy of `r`, so no lane exchanges data with another. Each lane reduces its columns one after another with a single sequential multiply-accumulate unit, with no adder tree. With more columns per lane the pass takes proportionally longer and needs fewer multipliers. The host fills the memories through a simple write port before it starts a pass.

Top module: `corr_bank`

## Requirements
- R1: Each emitted `out_corr` equals the exact sum over all `NSAMP` samples of `r[k] * S[k][j]`. Operands are 8-bit two's complement and the result is `2*DW + clog2(NSAMP)` bits (23 by default) of two's complement. This holds at both operand extremes, -128 and +127.
- R2: Column `j` is handled by lane `p = j mod LANES` in slot `s = j div LANES`. Call the clock edge that samples `start` edge 0. Then `out_valid` for column `j` is high in the cycle that follows edge `s*NSAMP + NSAMP + 2 + p`, and it is low in every other cycle of the pass.
- R3: Within a pass every column index `0..NCOL-1` is emitted exactly once, in ascending order. `out_idx` is always below `NCOL` while `out_valid` is high, and two valid cycles in a row carry indices that differ by one.
- R4: `done` is high for exactly one cycle, the cycle right after the one that carries index `NCOL-1`. It is never high together with `out_valid`.
- R5: A `start` pulse is ignored from the edge that accepts a pass up to and including the edge at which `done` is high. Such a pulse changes neither the timing nor the values of the running pass, and it does not launch another pass.
- R6: The accumulator restarts at the first sample of every column. A result therefore never depends on the column or pass computed before it.
- R7: A write with `wr_en=1` and `wr_mat=1` stores `wr_data` as `S[wr_smp][wr_col]`. With `wr_mat=0` it stores `wr_data` as `r[wr_smp]`. A write changes only that one entry, and the next pass uses the new value.
- R8: After reset `out_valid` and `done` are low, and they stay low while memories are written and no pass has been started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a pass when the block is idle |
| wr_en | input | 1 | Write strobe for the memories |
| wr_mat | input | 1 | 1: matrix entry, 0: received sample |
| wr_col | input | clog2(NCOL) | Matrix column of the write |
| wr_smp | input | clog2(NSAMP) | Sample (row) index of the write |
| wr_data | input | DW | Signed value written |
| out_valid | output | 1 | A correlation is present this cycle |
| out_idx | output | clog2(NCOL) | Column index of the correlation |
| out_corr | output | 2*DW+clog2(NSAMP) | Signed correlation value |
| done | output | 1 | One-cycle pulse after the last correlation |

## Verification
The bench builds the block with `NSAMP=88`, `NCOL=88` and `LANES=3`. That gives 30 slots per lane, so the final slot holds only column 87 and the serializer's short last slot and the uneven lane loads are exercised. The reference model predicts the exact cycle of every result from the lane and slot of each column. It checks all-maximum and opposite-sign extreme operands against the accumulator width. It rewrites a single matrix entry between passes, and it fires `start` both mid-pass and in the `done` cycle to show that such pulses are ignored.

// File: rtl/corr_pkg.sv
// Shared types and helpers for the correlator bank.
package corr_pkg;

    // Sequencer states: idle, issuing reads, waiting for the last result to drain
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_WAIT = 2'd2
    } seq_state_t;

    // Ceiling division for slot counts
    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/corr_seq.sv
// Pass sequencer. It walks every slot and every sample once per pass and
// drives the shared read address for all lanes. It then delays the control
// flags by one cycle to line them up with the registered memory read.
// Assumes: NSAMP >= 2, NSLOT >= 1; pass_done arrives once per pass.
module corr_seq #(
    parameter int NSAMP = 88,
    parameter int NSLOT = 22,
    localparam int SW = $clog2(NSAMP),
    localparam int TW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          pass_done,
    output logic          iss_v,
    output logic [TW-1:0] iss_slot,
    output logic [SW-1:0] iss_smp,
    output logic          mac_v,
    output logic          mac_first,
    output logic          mac_last,
    output logic [TW-1:0] mac_slot,
    output logic          mac_final
);
    import corr_pkg::*;

    localparam logic [SW-1:0] K_LAST = SW'(NSAMP - 1);
    localparam logic [TW-1:0] S_LAST = TW'(NSLOT - 1);

    seq_state_t    state;
    logic [SW-1:0] k;
    logic [TW-1:0] slot;

    // Pass state machine and sample/slot counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            k     <= '0;
            slot  <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (start) begin
                    state <= SQ_RUN;
                    k     <= '0;
                    slot  <= '0;
                end
                SQ_RUN: begin
                    if (k == K_LAST) begin
                        k <= '0;
                        if (slot == S_LAST) state <= SQ_WAIT;
                        else                slot  <= slot + TW'(1);
                    end else begin
                        k <= k + SW'(1);
                    end
                end
                SQ_WAIT: if (pass_done) state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Read issue is live whenever the machine is running
    always_comb begin
        iss_v    = (state == SQ_RUN);
        iss_slot = slot;
        iss_smp  = k;
    end

    // Control flags delayed to the MAC stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mac_v     <= 1'b0;
            mac_first <= 1'b0;
            mac_last  <= 1'b0;
            mac_slot  <= '0;
            mac_final <= 1'b0;
        end else begin
            mac_v     <= iss_v;
            mac_first <= iss_v && (k == '0);
            mac_last  <= iss_v && (k == K_LAST);
            mac_slot  <= slot;
            mac_final <= iss_v && (slot == S_LAST);
        end
    end

endmodule

// File: rtl/corr_lane.sv
// One correlator lane. It holds its own column memory and a private copy of
// the received vector, reads one entry of each per cycle, and accumulates
// the products in a single MAC. The finished sum of each column is held in res.
// Assumes: the caller never writes a slot/sample out of range.
module corr_lane #(
    parameter int NSAMP = 88,
    parameter int NSLOT = 22,
    parameter int DW    = 8,
    localparam int SW    = $clog2(NSAMP),
    localparam int TW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int AW    = 2 * DW + $clog2(NSAMP),
    localparam int DEPTH = NSAMP * NSLOT,
    localparam int MAW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_r,
    input  logic                 wr_m,
    input  logic [SW-1:0]        wr_smp,
    input  logic [TW-1:0]        wr_slot,
    input  logic signed [DW-1:0] wr_data,
    input  logic                 iss_v,
    input  logic [TW-1:0]        iss_slot,
    input  logic [SW-1:0]        iss_smp,
    input  logic                 mac_v,
    input  logic                 mac_first,
    input  logic                 mac_last,
    output logic signed [AW-1:0] res
);

    logic signed [DW-1:0]   mat_mem [DEPTH];
    logic signed [DW-1:0]   smp_mem [NSAMP];
    logic signed [DW-1:0]   m_q, r_q;
    logic signed [2*DW-1:0] prod;
    logic signed [AW-1:0]   acc, acc_next;

    function automatic logic [MAW-1:0] addr_of(input logic [TW-1:0] s, input logic [SW-1:0] k);
        return MAW'(s) * MAW'(NSAMP) + MAW'(k);
    endfunction

    // Host writes into the local memories
    always_ff @(posedge clk) begin
        if (wr_m) mat_mem[addr_of(wr_slot, wr_smp)] <= wr_data;
        if (wr_r) smp_mem[wr_smp] <= wr_data;
    end

    // Registered read of the matrix entry and the matching sample
    always_ff @(posedge clk) begin
        if (iss_v) begin
            m_q <= mat_mem[addr_of(iss_slot, iss_smp)];
            r_q <= smp_mem[iss_smp];
        end
    end

    // Product sign-extended and added, or loaded on a column's first sample
    always_comb begin
        prod     = m_q * r_q;
        acc_next = {{(AW - 2 * DW){prod[2*DW-1]}}, prod};
        if (!mac_first) acc_next = acc + acc_next;
    end

    // Accumulator and per-column result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            res <= '0;
        end else if (mac_v) begin
            acc <= acc_next;
            if (mac_last) res <= acc_next;
        end
    end

endmodule

// File: rtl/corr_emit.sv
// Result serializer. When a slot finishes, it walks the lanes in ascending
// order and presents one result per cycle with its column index. After the
// final slot it raises done for one cycle.
// Assumes: NSAMP > LANES, so a slot is fully emitted before the next one lands.
module corr_emit #(
    parameter int NCOL  = 88,
    parameter int LANES = 4,
    parameter int NSLOT = 22,
    parameter int AW    = 23,
    localparam int CW = $clog2(NCOL),
    localparam int TW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int PW = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int LAST_CNT = NCOL - (NSLOT - 1) * LANES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [TW-1:0]          load_slot,
    input  logic                   load_final,
    input  logic [LANES*AW-1:0]    res_flat,
    output logic                   out_valid,
    output logic [CW-1:0]          out_idx,
    output logic signed [AW-1:0]   out_corr,
    output logic                   done
);

    localparam logic [PW-1:0] LIM_FULL = PW'(LANES - 1);
    localparam logic [PW-1:0] LIM_LAST = PW'(LAST_CNT - 1);

    logic          busy, fin, tail;
    logic [PW-1:0] ptr, lim;
    logic [TW-1:0] base;
    logic [CW-1:0] col;

    // Column index and lane limit of the current step
    always_comb begin
        col = CW'(base) * CW'(LANES) + CW'(ptr);
        lim = fin ? LIM_LAST : LIM_FULL;
    end

    // Walk the lanes of a finished slot, then flag the end of the pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            fin       <= 1'b0;
            tail      <= 1'b0;
            ptr       <= '0;
            base      <= '0;
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_corr  <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            done      <= tail;
            tail      <= 1'b0;
            if (busy) begin
                out_valid <= 1'b1;
                out_idx   <= col;
                out_corr  <= res_flat[ptr*AW +: AW];
                if (ptr == lim) begin
                    busy <= 1'b0;
                    tail <= fin;
                end else begin
                    ptr <= ptr + PW'(1);
                end
            end
            if (load) begin
                busy <= 1'b1;
                ptr  <= '0;
                base <= load_slot;
                fin  <= load_final;
            end
        end
    end

endmodule

// File: rtl/corr_bank.sv
// Column-partitioned correlator bank top. It splits the matrix round-robin
// by column over LANES local lanes, runs them in lockstep from one
// sequencer, and serializes their results in column order.
// Assumes: NCOL >= 2, LANES <= NCOL, NSAMP > LANES; no writes during a pass.
module corr_bank #(
    parameter int NSAMP = 88,
    parameter int NCOL  = 88,
    parameter int LANES = 4,
    parameter int DW    = 8,
    localparam int NSLOT = corr_pkg::cdiv(NCOL, LANES),
    localparam int SW    = $clog2(NSAMP),
    localparam int CW    = $clog2(NCOL),
    localparam int TW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int AW    = 2 * DW + $clog2(NSAMP)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 wr_en,
    input  logic                 wr_mat,
    input  logic [CW-1:0]        wr_col,
    input  logic [SW-1:0]        wr_smp,
    input  logic signed [DW-1:0] wr_data,
    output logic                 out_valid,
    output logic [CW-1:0]        out_idx,
    output logic signed [AW-1:0] out_corr,
    output logic                 done
);

    logic                 iss_v, mac_v, mac_first, mac_last, mac_final;
    logic [TW-1:0]        iss_slot, mac_slot, wr_slot;
    logic [SW-1:0]        iss_smp;
    logic [CW-1:0]        wr_lane, wr_quot;
    logic                 wr_ok;
    logic [LANES*AW-1:0]  res_flat;

    // Route a host write to its lane and slot, dropping out-of-range indices
    always_comb begin
        wr_lane = wr_col % CW'(LANES);
        wr_quot = wr_col / CW'(LANES);
        wr_slot = TW'(wr_quot);
        wr_ok   = wr_en && ({1'b0, wr_col} < (CW+1)'(NCOL))
                        && ({1'b0, wr_smp} < (SW+1)'(NSAMP));
    end

    corr_seq #(.NSAMP(NSAMP), .NSLOT(NSLOT)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pass_done (done),
        .iss_v     (iss_v),
        .iss_slot  (iss_slot),
        .iss_smp   (iss_smp),
        .mac_v     (mac_v),
        .mac_first (mac_first),
        .mac_last  (mac_last),
        .mac_slot  (mac_slot),
        .mac_final (mac_final)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [AW-1:0] lane_res;

        corr_lane #(.NSAMP(NSAMP), .NSLOT(NSLOT), .DW(DW)) i_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_r      (wr_ok && !wr_mat),
            .wr_m      (wr_ok && wr_mat && (wr_lane == CW'(g))),
            .wr_smp    (wr_smp),
            .wr_slot   (wr_slot),
            .wr_data   (wr_data),
            .iss_v     (iss_v),
            .iss_slot  (iss_slot),
            .iss_smp   (iss_smp),
            .mac_v     (mac_v),
            .mac_first (mac_first),
            .mac_last  (mac_last),
            .res       (lane_res)
        );

        assign res_flat[g*AW +: AW] = lane_res;
    end

    corr_emit #(.NCOL(NCOL), .LANES(LANES), .NSLOT(NSLOT), .AW(AW)) i_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (mac_last),
        .load_slot  (mac_slot),
        .load_final (mac_final),
        .res_flat   (res_flat),
        .out_valid  (out_valid),
        .out_idx    (out_idx),
        .out_corr   (out_corr),
        .done       (done)
    );

endmodule

// File: rtl/corr_bank_chk.sv
// Protocol checker for the correlator bank output stream, bound to the top.
// Assumes: the same NCOL as the bound instance.
module corr_bank_chk #(
    parameter int NCOL = 88,
    localparam int CW = $clog2(NCOL)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_valid,
    input logic [CW-1:0] out_idx,
    input logic          done
);

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(out_valid) |-> out_idx == $past(out_idx) + CW'(1));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> {1'b0, out_idx} < (CW+1)'(NCOL));

    // R4
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid) && $past(out_idx) == CW'(NCOL - 1));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && out_valid));

endmodule

bind corr_bank corr_bank_chk #(.NCOL(NCOL)) i_corr_bank_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .done      (done)
);

// File: tb/test_corr_bank.sv
// Self-checking bench: behavioural reference of sums and result timing,
// compared against the outputs on every clock of each pass.
module test_corr_bank;
    localparam int NS = 88;
    localparam int NC = 88;
    localparam int LN = 3;
    localparam int DW = 8;
    localparam int SW = $clog2(NS);
    localparam int CW = $clog2(NC);
    localparam int AW = 2 * DW + $clog2(NS);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 wr_en = 1'b0;
    logic                 wr_mat = 1'b0;
    logic [CW-1:0]        wr_col = '0;
    logic [SW-1:0]        wr_smp = '0;
    logic signed [DW-1:0] wr_data = '0;
    logic                 out_valid;
    logic [CW-1:0]        out_idx;
    logic signed [AW-1:0] out_corr;
    logic                 done;

    int nchk = 0;
    int nfail = 0;
    int rv [NS];
    int sm [NS][NC];
    int ecor [NC];
    int at_col [int];

    always #5 clk = ~clk;

    corr_bank #(.NSAMP(NS), .NCOL(NC), .LANES(LN), .DW(DW)) i_corr_bank (
        .clk(clk), .rst_n(rst_n), .start(start),
        .wr_en(wr_en), .wr_mat(wr_mat), .wr_col(wr_col), .wr_smp(wr_smp), .wr_data(wr_data),
        .out_valid(out_valid), .out_idx(out_idx), .out_corr(out_corr), .done(done)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    task automatic put(input bit m, input int c, input int k, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_mat = m; wr_col = CW'(c); wr_smp = SW'(k); wr_data = DW'(v);
        if (m) sm[k][c] = v; else rv[k] = v;
    endtask

    task automatic put_end();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // mode 0: random, 1: all -128, 2: r=-128 and S=+127
    task automatic load_all(input int mode);
        for (int k = 0; k < NS; k++)
            put(1'b0, 0, k, (mode == 0) ? int'($urandom_range(255, 0)) - 128 : -128);
        for (int j = 0; j < NC; j++)
            for (int k = 0; k < NS; k++)
                put(1'b1, j, k, (mode == 0) ? int'($urandom_range(255, 0)) - 128 :
                                (mode == 1) ? -128 : 127);
        put_end();
        chk(out_valid === 1'b0 && done === 1'b0, "R8 idle while loading", out_valid, 0);
    endtask

    task automatic run_pass();
        int last;
        int span;
        at_col.delete();
        last = 0;
        for (int j = 0; j < NC; j++) begin
            int n;
            ecor[j] = 0;
            for (int k = 0; k < NS; k++) ecor[j] += rv[k] * sm[k][j];
            n = (j / LN) * NS + NS + 2 + (j % LN);   // R2 lane/slot timing
            at_col[n] = j;
            if (n > last) last = n;
        end
        span = last + NS + 6;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;               // edge 0 has passed
        for (int n = 1; n <= span; n++) begin
            @(negedge clk);
            // R5: pulses mid-pass and in the done cycle must be ignored
            start = (n == 40) || (n == last + 1);
            if (at_col.exists(n)) begin
                chk(out_valid === 1'b1, "R2 valid", int'(out_valid), 1);
                chk(int'(out_idx) == at_col[n], "R3 index", int'(out_idx), at_col[n]);
                chk(int'(out_corr) == ecor[at_col[n]], "R1/R6 value", int'(out_corr), ecor[at_col[n]]);
            end else begin
                chk(out_valid === 1'b0, "R2/R5 no output", int'(out_valid), 0);
            end
            chk(done === (n == last + 1), "R4 done", int'(done), int'(n == last + 1));
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(out_valid === 1'b0 && done === 1'b0, "R8 reset state", int'(out_valid), 0);
        end
        load_all(0);
        run_pass();                                // R1 random
        put(1'b1, 40, 5, (sm[5][40] == 100) ? -100 : 100);   // R7 single entry
        put_end();
        run_pass();                                // R7 only column 40 moves
        put(1'b0, 0, 17, (rv[17] == -7) ? 7 : -7); // R7 sample write
        put_end();
        run_pass();
        load_all(1);
        run_pass();                                // R1 positive extreme
        load_all(2);
        run_pass();                                // R1 negative extreme
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule